// File: doc/BRIEF.md
# Dual-Issue Pipe Steering Unit

This unit sits at the issue point of a two-wide in-order core. Each cycle it receives an ordered pair of decoded instructions: slot 0 is the older and slot 1 the younger. It decides how many of them leave the decode stage, and it routes each one that leaves onto one of two execution pipes. The two pipes do not accept the same work. The function pipe (F) takes integer, branch and floating-point work, plus anything that touches the HI/LO multiply registers. The memory pipe (M) takes integer and load/store work.

The consumed count is combinational, so the front end can advance its instruction queue in the same cycle. The routed instructions are captured in a per-pipe issue register at the next clock edge. Each pipe then carries a valid bit and the destination register index down a shift chain of `PIPE_STAGES` registers. The last register of that chain is the register-write stage, where the result commits.

Only one hazard is checked: the younger instruction reading a register that the older one writes in the same pair.

Top module: `pipe_steer`

## Requirements
- R1: Class codes are 0 = integer, 1 = load/store, 2 = branch, 3 = floating point. Branch and floating-point instructions are only ever routed to the F pipe.
- R2: A load/store instruction is only ever routed to the M pipe.
- R3: An integer instruction with its HI/LO flag set (multiply, divide, move from HI/LO) is only routed to the F pipe. The flag has no effect on the other classes.
- R4: Each pipe receives at most one instruction per cycle. If both instructions need the same pipe (both F-only or both M-only), only the older one issues and the count is 1.
- R5: When both instructions are plain integer and pair, the older goes to F and the younger to M.
- R6: When the pair can issue in only one arrangement, the unit uses that arrangement. In particular, a plain-integer older instruction moves to M when the younger needs F.
- R7: If the younger instruction reads (source A or B) the nonzero destination register of the older, only the older issues. Register index 0 never creates this dependency.
- R8: Issue is in order. If the older slot is not valid, nothing issues and the count is 0, whatever the younger slot holds.
- R9: `takeCount` (0, 1 or 2) reflects the current inputs in the same cycle. After the next edge, each pipe's issue outputs show valid, the source slot (0 = older), the class and the destination of the instruction routed there. When a pipe receives nothing, all its issue fields read zero.
- R10: Each pipe's writeback outputs show the valid bit and the destination `PIPE_STAGES-1` cycles after that instruction appeared on the issue outputs (default 5 stages).
- R11: While reset is held, every valid output and every routed field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0Valid | input | 1 | Older slot holds an instruction |
| s0Class | input | 2 | Older slot class code |
| s0Hilo | input | 1 | Older slot touches HI/LO |
| s0Dst | input | REG_IDX_W | Older slot destination register |
| s1Valid | input | 1 | Younger slot holds an instruction |
| s1Class | input | 2 | Younger slot class code |
| s1Hilo | input | 1 | Younger slot touches HI/LO |
| s1SrcA | input | REG_IDX_W | Younger slot first source register |
| s1SrcB | input | REG_IDX_W | Younger slot second source register |
| s1Dst | input | REG_IDX_W | Younger slot destination register |
| takeCount | output | 2 | Instructions consumed this cycle |
| fValid | output | 1 | F pipe issue register valid |
| fSlot | output | 1 | Slot routed to F (0 = older) |
| fClass | output | 2 | Class held in F issue register |
| fDst | output | REG_IDX_W | Destination held in F issue register |
| mValid | output | 1 | M pipe issue register valid |
| mSlot | output | 1 | Slot routed to M (0 = older) |
| mClass | output | 2 | Class held in M issue register |
| mDst | output | REG_IDX_W | Destination held in M issue register |
| fWbValid | output | 1 | F pipe register-write stage valid |
| fWbDst | output | REG_IDX_W | F pipe register-write destination |
| mWbValid | output | 1 | M pipe register-write stage valid |
| mWbDst | output | REG_IDX_W | M pipe register-write destination |

## Verification
The bench walks every combination of slot valids, both class codes and both HI/LO flags, and crosses them with four dependency patterns. One of those patterns is a destination of register 0 matched by a source of 0. A unit that steered a plain-integer older instruction greedily to F would fail to pair with a younger branch or floating-point instruction and report a count of 1. One that ignored the register-0 rule would split pairs that are actually independent. The bench also aims at a younger instruction presented alone: a unit that let it slip past an empty older slot would issue out of order. Finally, every issued instruction is followed to the register-write outputs. An off-by-one in the stage chain would show the destination in the wrong cycle.

// File: rtl/steer_pkg.sv
package steer_pkg;

  typedef enum logic [1:0] {
    CLS_INT    = 2'd0,
    CLS_MEM    = 2'd1,
    CLS_BRANCH = 2'd2,
    CLS_FLOAT  = 2'd3
  } instClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic fLoad;   // F pipe accepts an instruction
    logic mLoad;   // M pipe accepts an instruction
    logic fSel;    // slot feeding F (0 = older)
    logic mSel;    // slot feeding M (0 = older)
  } steerCtl_t;

endpackage

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import steer_pkg::*;
#(
  parameter int REG_IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s0Valid,
  input  instClass_e           s0Class,
  input  logic                 s0Hilo,
  input  logic [REG_IDX_W-1:0] s0Dst,
  input  logic                 s1Valid,
  input  instClass_e           s1Class,
  input  logic                 s1Hilo,
  input  logic [REG_IDX_W-1:0] s1SrcA,
  input  logic [REG_IDX_W-1:0] s1SrcB,
  output steerCtl_t            ctl,
  output logic [1:0]           takeCount
);

  function automatic logic needsF(instClass_e c, logic hilo);
    return (c == CLS_BRANCH) || (c == CLS_FLOAT) || ((c == CLS_INT) && hilo);
  endfunction

  function automatic logic needsM(instClass_e c);
    return (c == CLS_MEM);
  endfunction

  logic f0Only, f1Only, m0Only, m1Only;
  logic rawHazard, pipeClash, pairOk, swapOrder;

  always_comb begin
    f0Only    = needsF(s0Class, s0Hilo);
    f1Only    = needsF(s1Class, s1Hilo);
    m0Only    = needsM(s0Class);
    m1Only    = needsM(s1Class);
    rawHazard = (s0Dst != '0) && ((s1SrcA == s0Dst) || (s1SrcB == s0Dst));
    pipeClash = (f0Only && f1Only) || (m0Only && m1Only);
    pairOk    = s0Valid && s1Valid && !rawHazard && !pipeClash;
    // older goes to M only when one side forces it
    swapOrder = m0Only || f1Only;
  end

  always_comb begin
    ctl = '0;
    if (pairOk) begin
      ctl.fLoad = 1'b1;
      ctl.mLoad = 1'b1;
      ctl.fSel  = swapOrder;
      ctl.mSel  = !swapOrder;
    end else if (s0Valid) begin
      if (m0Only) begin
        ctl.mLoad = 1'b1;
      end else begin
        ctl.fLoad = 1'b1;
      end
    end
  end

  always_comb begin
    if (pairOk)       takeCount = 2'd2;
    else if (s0Valid) takeCount = 2'd1;
    else              takeCount = 2'd0;
  end

  // R4: the two pipes never draw from the same slot
  assert_one_per_pipe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.fLoad && ctl.mLoad) |-> (ctl.fSel != ctl.mSel));

  // R9: consumed count agrees with the pipe loads
  assert_count_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
    takeCount == ({1'b0, ctl.fLoad} + {1'b0, ctl.mLoad}));

  // R2: an older load/store lands on M
  assert_mem_to_m_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s0Valid && s0Class == CLS_MEM) |-> (ctl.mLoad && !ctl.mSel));

  // R7: a read-after-write inside the pair splits it
  assert_pair_hazard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s0Valid && s1Valid && s0Dst != '0 && (s1SrcA == s0Dst || s1SrcB == s0Dst))
      |-> (takeCount == 2'd1));

  // R8: no issue past an empty older slot
  assert_in_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !s0Valid |-> (takeCount == 2'd0));

endmodule

// File: rtl/steer_lane.sv
module steer_lane #(
  parameter int REG_IDX_W   = 5,
  parameter int PIPE_STAGES = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 sel,
  input  logic [1:0]           cls,
  input  logic [REG_IDX_W-1:0] dst,
  output logic                 issueValid,
  output logic                 issueSlot,
  output logic [1:0]           issueClass,
  output logic [REG_IDX_W-1:0] issueDst,
  output logic                 wbValid,
  output logic [REG_IDX_W-1:0] wbDst
);

  localparam int LAST = PIPE_STAGES - 1;

  typedef struct packed {
    logic                 v;
    logic                 slot;
    logic [1:0]           cls;
    logic [REG_IDX_W-1:0] dst;
  } stage_t;

  stage_t stg [PIPE_STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg[0] <= '0;
    end else if (load) begin
      stg[0] <= '{v: 1'b1, slot: sel, cls: cls, dst: dst};
    end else begin
      stg[0] <= '0;
    end
  end

  for (genvar k = 1; k < PIPE_STAGES; k++) begin : g_chain
    always_ff @(posedge clk) begin
      if (!rst_n) stg[k] <= '0;
      else        stg[k] <= stg[k-1];
    end

    // R10: each stage follows its predecessor by one cycle
    assert_stage_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stg[k].v == $past(stg[k-1].v)) && (stg[k].dst == $past(stg[k-1].dst)));
  end

  assign issueValid = stg[0].v;
  assign issueSlot  = stg[0].slot;
  assign issueClass = stg[0].cls;
  assign issueDst   = stg[0].dst;
  assign wbValid    = stg[LAST].v;
  assign wbDst      = stg[LAST].dst;

endmodule

// File: rtl/steer_datapath.sv
module steer_datapath
  import steer_pkg::*;
#(
  parameter int REG_IDX_W   = 5,
  parameter int PIPE_STAGES = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  steerCtl_t            ctl,
  input  logic [1:0]           s0Class,
  input  logic [REG_IDX_W-1:0] s0Dst,
  input  logic [1:0]           s1Class,
  input  logic [REG_IDX_W-1:0] s1Dst,
  output logic                 fValid,
  output logic                 fSlot,
  output logic [1:0]           fClass,
  output logic [REG_IDX_W-1:0] fDst,
  output logic                 mValid,
  output logic                 mSlot,
  output logic [1:0]           mClass,
  output logic [REG_IDX_W-1:0] mDst,
  output logic                 fWbValid,
  output logic [REG_IDX_W-1:0] fWbDst,
  output logic                 mWbValid,
  output logic [REG_IDX_W-1:0] mWbDst
);

  localparam int NUM_PIPES = 2;   // index 0 = F, 1 = M

  logic                 laneLoad   [NUM_PIPES];
  logic                 laneSel    [NUM_PIPES];
  logic                 laneValid  [NUM_PIPES];
  logic                 laneSlot   [NUM_PIPES];
  logic [1:0]           laneClass  [NUM_PIPES];
  logic [REG_IDX_W-1:0] laneDst    [NUM_PIPES];
  logic                 laneWbV    [NUM_PIPES];
  logic [REG_IDX_W-1:0] laneWbDst  [NUM_PIPES];

  assign laneLoad[0] = ctl.fLoad;
  assign laneSel[0]  = ctl.fSel;
  assign laneLoad[1] = ctl.mLoad;
  assign laneSel[1]  = ctl.mSel;

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    logic [1:0]           muxCls;
    logic [REG_IDX_W-1:0] muxDst;

    assign muxCls = laneSel[p] ? s1Class : s0Class;
    assign muxDst = laneSel[p] ? s1Dst   : s0Dst;

    steer_lane #(
      .REG_IDX_W  (REG_IDX_W),
      .PIPE_STAGES(PIPE_STAGES)
    ) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (laneLoad[p]),
      .sel       (laneSel[p]),
      .cls       (muxCls),
      .dst       (muxDst),
      .issueValid(laneValid[p]),
      .issueSlot (laneSlot[p]),
      .issueClass(laneClass[p]),
      .issueDst  (laneDst[p]),
      .wbValid   (laneWbV[p]),
      .wbDst     (laneWbDst[p])
    );
  end

  assign fValid   = laneValid[0];
  assign fSlot    = laneSlot[0];
  assign fClass   = laneClass[0];
  assign fDst     = laneDst[0];
  assign mValid   = laneValid[1];
  assign mSlot    = laneSlot[1];
  assign mClass   = laneClass[1];
  assign mDst     = laneDst[1];
  assign fWbValid = laneWbV[0];
  assign fWbDst   = laneWbDst[0];
  assign mWbValid = laneWbV[1];
  assign mWbDst   = laneWbDst[1];

  // R2: no load/store ever sits in the F issue register
  assert_no_mem_on_f_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fValid |-> (fClass != 2'd1));

  // R1: branch and floating point never sit in the M issue register
  assert_m_class_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mValid |-> (mClass == 2'd0 || mClass == 2'd1));

  // R4: a pair fills the two pipes from different slots
  assert_distinct_slots_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fValid && mValid) |-> (fSlot != mSlot));

endmodule

// File: rtl/pipe_steer.sv
module pipe_steer
  import steer_pkg::*;
#(
  parameter int REG_IDX_W   = 5,
  parameter int PIPE_STAGES = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s0Valid,
  input  logic [1:0]           s0Class,
  input  logic                 s0Hilo,
  input  logic [REG_IDX_W-1:0] s0Dst,
  input  logic                 s1Valid,
  input  logic [1:0]           s1Class,
  input  logic                 s1Hilo,
  input  logic [REG_IDX_W-1:0] s1SrcA,
  input  logic [REG_IDX_W-1:0] s1SrcB,
  input  logic [REG_IDX_W-1:0] s1Dst,
  output logic [1:0]           takeCount,
  output logic                 fValid,
  output logic                 fSlot,
  output logic [1:0]           fClass,
  output logic [REG_IDX_W-1:0] fDst,
  output logic                 mValid,
  output logic                 mSlot,
  output logic [1:0]           mClass,
  output logic [REG_IDX_W-1:0] mDst,
  output logic                 fWbValid,
  output logic [REG_IDX_W-1:0] fWbDst,
  output logic                 mWbValid,
  output logic [REG_IDX_W-1:0] mWbDst
);

  steerCtl_t ctl;

  steer_ctrl #(.REG_IDX_W(REG_IDX_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .s0Valid  (s0Valid),
    .s0Class  (instClass_e'(s0Class)),
    .s0Hilo   (s0Hilo),
    .s0Dst    (s0Dst),
    .s1Valid  (s1Valid),
    .s1Class  (instClass_e'(s1Class)),
    .s1Hilo   (s1Hilo),
    .s1SrcA   (s1SrcA),
    .s1SrcB   (s1SrcB),
    .ctl      (ctl),
    .takeCount(takeCount)
  );

  steer_datapath #(
    .REG_IDX_W  (REG_IDX_W),
    .PIPE_STAGES(PIPE_STAGES)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .s0Class (s0Class),
    .s0Dst   (s0Dst),
    .s1Class (s1Class),
    .s1Dst   (s1Dst),
    .fValid  (fValid),
    .fSlot   (fSlot),
    .fClass  (fClass),
    .fDst    (fDst),
    .mValid  (mValid),
    .mSlot   (mSlot),
    .mClass  (mClass),
    .mDst    (mDst),
    .fWbValid(fWbValid),
    .fWbDst  (fWbDst),
    .mWbValid(mWbValid),
    .mWbDst  (mWbDst)
  );

endmodule

// File: tb/pipe_steer_bench.sv
module pipe_steer_bench;

  localparam int W = 5;
  localparam int STAGES = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s0Valid = 1'b0, s0Hilo = 1'b0, s1Valid = 1'b0, s1Hilo = 1'b0;
  logic [1:0] s0Class = '0, s1Class = '0;
  logic [W-1:0] s0Dst = '0, s1SrcA = '0, s1SrcB = '0, s1Dst = '0;
  logic [1:0] takeCount;
  logic fValid, fSlot, mValid, mSlot, fWbValid, mWbValid;
  logic [1:0] fClass, mClass;
  logic [W-1:0] fDst, mDst, fWbDst, mWbDst;

  always #4 clk = ~clk;

  pipe_steer #(.REG_IDX_W(W), .PIPE_STAGES(STAGES)) u_pipe_steer (
    .clk(clk), .rst_n(rst_n),
    .s0Valid(s0Valid), .s0Class(s0Class), .s0Hilo(s0Hilo), .s0Dst(s0Dst),
    .s1Valid(s1Valid), .s1Class(s1Class), .s1Hilo(s1Hilo),
    .s1SrcA(s1SrcA), .s1SrcB(s1SrcB), .s1Dst(s1Dst),
    .takeCount(takeCount),
    .fValid(fValid), .fSlot(fSlot), .fClass(fClass), .fDst(fDst),
    .mValid(mValid), .mSlot(mSlot), .mClass(mClass), .mDst(mDst),
    .fWbValid(fWbValid), .fWbDst(fWbDst), .mWbValid(mWbValid), .mWbDst(mWbDst)
  );

  typedef struct packed {
    logic fV; logic fS; logic [1:0] fC; logic [W-1:0] fD;
    logic mV; logic mS; logic [1:0] mC; logic [W-1:0] mD;
  } rec_t;

  rec_t hist [STAGES];
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // expected steering, from the requirements
  task automatic predict(output rec_t r, output int cnt, output string tag);
    bit fOk0, fOk1, mOk0, mOk1, dep, pair;
    fOk0 = (s0Class != 2'd1);
    fOk1 = (s1Class != 2'd1);
    mOk0 = (s0Class == 2'd1) || (s0Class == 2'd0 && !s0Hilo);
    mOk1 = (s1Class == 2'd1) || (s1Class == 2'd0 && !s1Hilo);
    dep  = (s0Dst != 0) && (s1SrcA == s0Dst || s1SrcB == s0Dst);
    pair = s0Valid && s1Valid && !dep && ((fOk0 && mOk1) || (mOk0 && fOk1));
    r = '0;
    if (pair) begin
      cnt = 2;
      if (fOk0 && mOk1) begin
        r.fV = 1; r.fS = 0; r.fC = s0Class; r.fD = s0Dst;
        r.mV = 1; r.mS = 1; r.mC = s1Class; r.mD = s1Dst;
      end else begin
        r.mV = 1; r.mS = 0; r.mC = s0Class; r.mD = s0Dst;
        r.fV = 1; r.fS = 1; r.fC = s1Class; r.fD = s1Dst;
      end
    end else if (s0Valid) begin
      cnt = 1;
      if (fOk0) begin r.fV = 1; r.fC = s0Class; r.fD = s0Dst; end
      else      begin r.mV = 1; r.mC = s0Class; r.mD = s0Dst; end
    end else begin
      cnt = 0;
    end
    if (!s0Valid)                               tag = "R8";
    else if (s1Valid && dep)                    tag = "R7";
    else if (s0Class == 2'd1 || s1Class == 2'd1) tag = "R2";
    else if (s0Hilo || s1Hilo)                  tag = "R3";
    else if (s1Valid && !pair)                  tag = "R4";
    else if (s0Class == 2'd0 && s1Class == 2'd0) tag = "R5";
    else if (s1Valid && s1Class[1] && s0Class == 2'd0) tag = "R6";
    else                                        tag = "R1";
  endtask

  task automatic checkOutputs();
    // issue register holds the latest routing, write stage the one from STAGES-1 edges earlier
    check("R9", "fValid", fValid, hist[0].fV);
    check("R9", "fSlot", fSlot, hist[0].fS);
    check("R9", "fClass", fClass, hist[0].fC);
    check("R9", "fDst", fDst, hist[0].fD);
    check("R9", "mValid", mValid, hist[0].mV);
    check("R9", "mSlot", mSlot, hist[0].mS);
    check("R9", "mClass", mClass, hist[0].mC);
    check("R9", "mDst", mDst, hist[0].mD);
    check("R10", "fWbValid", fWbValid, hist[STAGES-1].fV);
    check("R10", "fWbDst", fWbDst, hist[STAGES-1].fD);
    check("R10", "mWbValid", mWbValid, hist[STAGES-1].mV);
    check("R10", "mWbDst", mWbDst, hist[STAGES-1].mD);
  endtask

  task automatic step();
    rec_t r;
    int cnt;
    string tag;
    #1;
    predict(r, cnt, tag);
    check(tag, "takeCount", takeCount, cnt);
    for (int k = STAGES - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = r;
    @(negedge clk);
    checkOutputs();
  endtask

  initial begin
    for (int k = 0; k < STAGES; k++) hist[k] = '0;
    repeat (3) @(negedge clk);
    // R11: everything idle under reset
    s0Valid = 1; s1Valid = 1; s0Dst = 5'd3; s1Dst = 5'd4;
    @(negedge clk);
    check("R11", "fValid", fValid, 0);
    check("R11", "mValid", mValid, 0);
    check("R11", "fWbValid", fWbValid, 0);
    check("R11", "mWbValid", mWbValid, 0);
    check("R11", "fDst", fDst, 0);
    check("R11", "mDst", mDst, 0);
    s0Valid = 0; s1Valid = 0; s0Dst = 0; s1Dst = 0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int v = 0; v < 4; v++)
      for (int c0 = 0; c0 < 4; c0++)
        for (int c1 = 0; c1 < 4; c1++)
          for (int h = 0; h < 4; h++)
            for (int d = 0; d < 4; d++) begin
              s0Valid = v[0]; s1Valid = v[1];
              s0Class = c0[1:0]; s1Class = c1[1:0];
              s0Hilo = h[0]; s1Hilo = h[1];
              s1Dst = 5'(9 + c1);
              case (d)
                0: begin s0Dst = 5'd7; s1SrcA = 5'd3; s1SrcB = 5'd4; end
                1: begin s0Dst = 5'd7; s1SrcA = 5'd3; s1SrcB = 5'd7; end
                2: begin s0Dst = 5'd0; s1SrcA = 5'd0; s1SrcB = 5'd0; end
                default: begin s0Dst = 5'd7; s1SrcA = 5'd7; s1SrcB = 5'd2; end
              endcase
              step();
            end
    s0Valid = 0; s1Valid = 0;
    for (int i = 0; i < STAGES + 1; i++) step();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule